// File: doc/BRIEF.md
# Bundled Control-Code Issue Sequencer

This block sits in front of an issue stage that reads an instruction stream in which a 64-bit scheduling header comes before each fixed-length group of instructions. The header holds one 8-bit control section per instruction in the group. The sequencer takes the header off the stream and keeps it. It then lets the group's instructions through one at a time. For each instruction it decodes that instruction's section and reports a stall count, three dependency-barrier flags and a dual-issue pairing mark. Before the next instruction may leave, the block enforces the stall count and waits for completion of any barrier that was raised.

Both stream sides use valid/ready. A header is taken whenever one is offered, and it never appears on the output. During the instruction phase the block is a combinational pass-through with a gate. The output's valid follows the input's valid only while the gate is open. The input's ready follows the output's ready only while the gate is open. When the gate is shut, the input is stalled and nothing is offered downstream. A stalled downstream therefore holds the current instruction at the input. The upstream side may change or withdraw an instruction that has not been accepted. Completion of a barrier is signalled by three plain level inputs, one for each memory class.

Top module: `ccs_sequencer`

## Requirements
- R1: In the header phase `in_ready` is 1 whatever `out_ready` is. A word accepted there is stored as the header and is never forwarded, so `out_valid` stays 0.
- R2: One cycle after a header is accepted, `hdr_err` is 1 if any of header bits 63..58 or 1..0 is non-zero, and 0 otherwise. It holds that value until the next header is accepted.
- R3: After a header, exactly `BUNDLE` instructions (default 7) are forwarded. The next word accepted after them is a header.
- R4: The k-th instruction after a header (k counted from 0) takes its attributes from header bits 2+8k to 9+8k.
- R5: `out_stall` is the section's bits 3..0, with code 0 reported as 16. When an instruction with stall n is transferred at clock edge t, the next instruction cannot transfer before edge t+n.
- R6: `out_bar_shared`, `out_bar_global` and `out_bar_texture` equal bits 4, 5 and 7 of the section.
- R7: A barrier flag carried by a transferred instruction stays pending until its completion input is 1 at a later clock edge. Completion seen at the same edge as the transfer is ignored. While any barrier is pending, no instruction is offered.
- R8: When section k equals 0x04 and section k+1 of the same header equals 0x05, both instructions carry `out_dual`=1. The first one's stall is waived, so the second may transfer on the very next edge.
- R9: In the instruction phase, `out_valid` = `in_valid` while the gate is open and 0 while it is shut. `out_insn` equals `in_data`. `in_ready` equals `out_ready` while the gate is open and 0 while it is shut.
- R10: After reset the block is in the header phase with `out_valid`=0, `in_ready`=1 and `hdr_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 64 | Header or instruction word |
| done_shared | input | 1 | Shared-memory barrier completion |
| done_global | input | 1 | Global-memory barrier completion |
| done_texture | input | 1 | Texture-cache barrier completion |
| out_valid | output | 1 | Instruction offered |
| out_ready | input | 1 | Downstream accepts instruction |
| out_insn | output | 64 | Instruction word |
| out_stall | output | 5 | Decoded stall count, 1 to 16 |
| out_bar_shared | output | 1 | Instruction raises shared-memory barrier |
| out_bar_global | output | 1 | Instruction raises global-memory barrier |
| out_bar_texture | output | 1 | Instruction raises texture-cache barrier |
| out_dual | output | 1 | Instruction is a member of a dual-issue pair |
| hdr_err | output | 1 | Latest header had a must-be-zero bit set |

## Verification
Several things can land on the same clock edge. A completion input can rise at the very edge where an instruction raising that barrier transfers. The stall countdown can also run out at the edge where a barrier completes, so the gate reopens for two reasons at once. The bench drives the completion inputs and `out_ready` pseudo-randomly against headers that mix barrier bits with short stalls, which makes these coincidences frequent. A behavioural reference model, compared on every cycle, then decides whether the same-edge completion was correctly ignored and whether the gate reopened on the right edge.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int CTRL_W   = 64;
  localparam int SEC_W    = 8;
  localparam int SECTIONS = 7;
  localparam int LO_PAD   = 2;
  localparam int HI_PAD   = CTRL_W - LO_PAD - SECTIONS * SEC_W;
  localparam int CODE_W   = 4;

  localparam logic [SEC_W-1:0] PAIR_HEAD = 8'h04;
  localparam logic [SEC_W-1:0] PAIR_TAIL = 8'h05;

  typedef enum logic {PH_HDR = 1'b0, PH_INSN = 1'b1} phase_t;

  // bars order: {texture, global, shared}
  typedef struct packed {
    logic [CODE_W-1:0] stall_code;
    logic [2:0]        bars;
    logic              dual_first;
    logic              dual_second;
  } sec_attr_t;
endpackage

// File: rtl/ccs_hdr_reg.sv
module ccs_hdr_reg
  import ccs_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [CTRL_W-1:0]         word,
  output logic [SECTIONS*SEC_W-1:0] secs,
  output logic                      err
);
  logic bad_bits;
  assign bad_bits = (|word[CTRL_W-1 -: HI_PAD]) | (|word[LO_PAD-1:0]);

  for (genvar k = 0; k < SECTIONS; k++) begin : g_sec
    logic [SEC_W-1:0] sec_q;
    always_ff @(posedge clk) begin
      if (!rst_n)    sec_q <= '0;
      else if (load) sec_q <= word[LO_PAD + k*SEC_W +: SEC_W];
    end
    assign secs[k*SEC_W +: SEC_W] = sec_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    err <= 1'b0;
    else if (load) err <= bad_bits;
  end
endmodule

// File: rtl/ccs_section_sel.sv
module ccs_section_sel
  import ccs_pkg::*;
#(
  parameter int BUNDLE = 7,
  parameter int IDX_W  = 3
) (
  input  logic [SECTIONS*SEC_W-1:0] secs,
  input  logic [IDX_W-1:0]          idx,
  output sec_attr_t                 attr
);
  logic [SEC_W-1:0] sec_arr [SECTIONS];
  logic [SECTIONS-1:0] pair_at;
  logic [SEC_W-1:0] cur;

  for (genvar k = 0; k < SECTIONS; k++) begin : g_unpack
    assign sec_arr[k] = secs[k*SEC_W +: SEC_W];
    if (k < BUNDLE - 1 && k < SECTIONS - 1) begin : g_pair
      assign pair_at[k] = (secs[k*SEC_W +: SEC_W] == PAIR_HEAD) &&
                          (secs[(k+1)*SEC_W +: SEC_W] == PAIR_TAIL);
    end else begin : g_nopair
      assign pair_at[k] = 1'b0;
    end
  end

  always_comb begin
    cur = '0;
    for (int k = 0; k < SECTIONS; k++)
      if (idx == IDX_W'(k)) cur = sec_arr[k];
  end

  always_comb begin
    attr.stall_code  = cur[CODE_W-1:0];
    attr.bars        = {cur[7], cur[5], cur[4]};
    attr.dual_first  = 1'b0;
    attr.dual_second = 1'b0;
    for (int k = 0; k < SECTIONS; k++) begin
      if (idx == IDX_W'(k)) attr.dual_first = pair_at[k];
      if (k > 0 && idx == IDX_W'(k)) attr.dual_second = pair_at[k-1];
    end
  end
endmodule

// File: rtl/ccs_issue_gate.sv
module ccs_issue_gate
  import ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] load_cnt,
  input  logic [2:0]        set_bars,
  input  logic [2:0]        done,
  output logic              open
);
  logic [CODE_W-1:0] cnt_q;
  logic [2:0]        pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (fire)          cnt_q <= load_cnt;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~done) | (fire ? set_bars : 3'b000);
  end

  assign open = (cnt_q == '0) && (pend_q == '0);
endmodule

// File: rtl/ccs_sequencer.sv
module ccs_sequencer
  import ccs_pkg::*;
#(
  parameter int BUNDLE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CTRL_W-1:0] in_data,
  input  logic              done_shared,
  input  logic              done_global,
  input  logic              done_texture,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CTRL_W-1:0] out_insn,
  output logic [CODE_W:0]   out_stall,
  output logic              out_bar_shared,
  output logic              out_bar_global,
  output logic              out_bar_texture,
  output logic              out_dual,
  output logic              hdr_err
);
  localparam int IDX_W = $clog2(SECTIONS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BUNDLE - 1);

  phase_t                    phase_q;
  logic [IDX_W-1:0]          idx_q;
  logic [SECTIONS*SEC_W-1:0] secs;
  sec_attr_t                 attr;
  logic                      hdr_take, fire, gate_open, in_insn;
  logic [CODE_W-1:0]         load_cnt;

  assign in_insn  = (phase_q == PH_INSN);
  assign hdr_take = (phase_q == PH_HDR) && in_valid;

  ccs_hdr_reg u_hdr (
    .clk(clk), .rst_n(rst_n), .load(hdr_take), .word(in_data),
    .secs(secs), .err(hdr_err)
  );

  ccs_section_sel #(.BUNDLE(BUNDLE), .IDX_W(IDX_W)) u_sel (
    .secs(secs), .idx(idx_q), .attr(attr)
  );

  always_comb begin
    if (attr.dual_first)              load_cnt = '0;
    else if (attr.stall_code == '0)   load_cnt = '1;
    else                              load_cnt = attr.stall_code - 1'b1;
  end

  ccs_issue_gate u_gate (
    .clk(clk), .rst_n(rst_n), .fire(fire), .load_cnt(load_cnt),
    .set_bars(attr.bars),
    .done({done_texture, done_global, done_shared}),
    .open(gate_open)
  );

  assign out_valid = in_insn && gate_open && in_valid;
  assign in_ready  = !in_insn || (gate_open && out_ready);
  assign fire      = out_valid && out_ready;

  assign out_insn        = in_data;
  assign out_stall       = {attr.stall_code == '0, attr.stall_code};
  assign out_bar_shared  = attr.bars[0];
  assign out_bar_global  = attr.bars[1];
  assign out_bar_texture = attr.bars[2];
  assign out_dual        = attr.dual_first | attr.dual_second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HDR;
      idx_q   <= '0;
    end else if (hdr_take) begin
      phase_q <= PH_INSN;
      idx_q   <= '0;
    end else if (fire) begin
      if (idx_q == LAST_IDX) phase_q <= PH_HDR;
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ccs_sequencer_chk.sv
module ccs_sequencer_chk
  import ccs_pkg::*;
#(
  parameter int BUNDLE = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CTRL_W-1:0] in_data,
  input logic              done_shared,
  input logic              done_global,
  input logic              done_texture,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CTRL_W-1:0] out_insn,
  input logic [CODE_W:0]   out_stall,
  input logic              out_bar_shared,
  input logic              out_bar_global,
  input logic              out_bar_texture,
  input logic              out_dual,
  input logic              hdr_err,
  input logic              hdr_take
);
  logic fire, bad;
  logic [4:0] since_q, req_q;
  logic [2:0] pend_c;
  logic [3:0] n_iss;
  logic       seen_hdr;

  assign fire = out_valid && out_ready;
  assign bad  = (|in_data[CTRL_W-1 -: HI_PAD]) | (|in_data[LO_PAD-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q  <= 5'd31;
      req_q    <= '0;
      pend_c   <= '0;
      n_iss    <= '0;
      seen_hdr <= 1'b0;
    end else begin
      if (fire) begin
        since_q <= 5'd1;
        req_q   <= out_dual ? 5'd1 : out_stall;
      end else if (since_q != 5'd31) begin
        since_q <= since_q + 1'b1;
      end
      pend_c <= (pend_c & ~{done_texture, done_global, done_shared}) |
                (fire ? {out_bar_texture, out_bar_global, out_bar_shared} : 3'b000);
      if (hdr_take) begin
        n_iss    <= '0;
        seen_hdr <= 1'b1;
      end else if (fire) begin
        n_iss <= n_iss + 1'b1;
      end
    end
  end

  assert_hdr_no_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |-> (in_ready && !out_valid));

  assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && bad) |=> hdr_err);

  assert_err_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && !bad) |=> !hdr_err);

  assert_bundle_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (n_iss < 4'(BUNDLE)));

  assert_bundle_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_take && seen_hdr) |-> (n_iss == 4'(BUNDLE)));

  assert_stall_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_stall != 5'd0 && out_stall <= 5'd16));

  assert_stall_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (since_q >= req_q));

  assert_barrier_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pend_c == 3'b000));

  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && out_insn == in_data));

  assert_ready_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_ready == out_ready));
endmodule

bind ccs_sequencer ccs_sequencer_chk #(.BUNDLE(BUNDLE)) u_chk (.*);

// File: tb/sim_ccs_sequencer.sv
module sim_ccs_sequencer;
  localparam int B = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0] in_data = '0;
  logic done_shared = 1'b0, done_global = 1'b0, done_texture = 1'b0;
  logic in_ready, out_valid, out_bar_shared, out_bar_global, out_bar_texture, out_dual, hdr_err;
  logic [63:0] out_insn;
  logic [4:0]  out_stall;

  ccs_sequencer #(.BUNDLE(B)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .done_shared(done_shared), .done_global(done_global),
    .done_texture(done_texture), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_stall(out_stall), .out_bar_shared(out_bar_shared),
    .out_bar_global(out_bar_global), .out_bar_texture(out_bar_texture),
    .out_dual(out_dual), .hdr_err(hdr_err)
  );

  int checks = 0, fails = 0, cyc = 0, serial = 0;
  logic [63:0] q[$];
  bit run = 0, rnd_ready = 0, rnd_done = 0, rnd_valid = 0;

  // reference model state
  int m_ph = 0, m_idx = 0, m_gap = 0;
  logic [2:0]  m_pend = '0;
  logic [63:0] m_hdr = '0;
  bit m_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push_bundle(input logic [7:0] s [7], input logic [63:0] pad);
    logic [63:0] h;
    h = pad;
    for (int k = 0; k < 7; k++) h[2 + 8*k +: 8] = s[k];
    q.push_back(h);
    for (int i = 0; i < B; i++) begin
      serial++;
      q.push_back({32'h1A5E_0000 + serial, $urandom()});
    end
  endtask

  function automatic logic [7:0] msec(input int k);
    return m_hdr[2 + 8*k +: 8];
  endfunction

  always @(negedge clk) begin
    if (run) begin
      logic [7:0] sec;
      int n;
      bit df, ds, open, e_ov, e_ir, fire;
      logic [2:0] flags, dn;
      if (q.size() > 0 && (!rnd_valid || $urandom_range(0, 3) != 0)) begin
        in_valid = 1'b1; in_data = q[0];
      end else begin
        in_valid = 1'b0; in_data = {$urandom(), $urandom()};
      end
      out_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      dn = rnd_done ? 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7)) : 3'b111;
      {done_texture, done_global, done_shared} = dn;
      #1;
      sec   = msec(m_idx);
      n     = (sec[3:0] == 0) ? 16 : int'(sec[3:0]);
      df    = (m_idx < B - 1) && sec == 8'h04 && msec(m_idx + 1) == 8'h05;
      ds    = (m_idx > 0) && sec == 8'h05 && msec(m_idx - 1) == 8'h04;
      flags = {sec[7], sec[5], sec[4]};
      open  = (m_ph == 1) && m_gap == 0 && m_pend == 0;
      e_ov  = open && in_valid;
      e_ir  = (m_ph == 0) ? 1'b1 : (open && out_ready);
      chk(in_ready == e_ir, "R1/R3/R9 in_ready", 64'(in_ready), 64'(e_ir));
      chk(out_valid == e_ov, "R5/R7/R8/R9 out_valid", 64'(out_valid), 64'(e_ov));
      chk(hdr_err == m_err, "R2 hdr_err", 64'(hdr_err), 64'(m_err));
      if (e_ov) begin
        chk(out_insn == in_data, "R9 out_insn", out_insn, in_data);
        chk(out_stall == 5'(n), "R4/R5 out_stall", 64'(out_stall), 64'(n));
        chk({out_bar_texture, out_bar_global, out_bar_shared} == flags,
            "R4/R6 barrier flags", 64'({out_bar_texture, out_bar_global, out_bar_shared}), 64'(flags));
        chk(out_dual == (df | ds), "R8 out_dual", 64'(out_dual), 64'(df | ds));
      end
      // advance model to the state after the coming edge
      fire = e_ov && out_ready;
      if (m_ph == 0 && in_valid) begin
        m_hdr = in_data;
        m_err = (|in_data[63:58]) | (|in_data[1:0]);
        m_ph  = 1; m_idx = 0;
      end
      if (fire) m_gap = df ? 0 : n - 1;
      else if (m_gap > 0) m_gap--;
      m_pend = (m_pend & ~dn) | (fire ? flags : 3'b000);
      if (fire) begin
        m_idx++;
        if (m_idx == B) m_ph = 0;
      end
      if (in_valid && e_ir) void'(q.pop_front());
      cyc++;
    end
  end

  task automatic drain();
    while (!(q.size() == 0 && m_ph == 0)) @(posedge clk);
    repeat (20) @(posedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, no completion");
    summary();
  end

  initial begin
    logic [7:0] s [7];
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R10: reset state
    chk(out_valid == 1'b0, "R10 out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", 64'(in_ready), 64'd1);
    chk(hdr_err == 1'b0, "R10 hdr_err in reset", 64'(hdr_err), 64'd0);
    @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hdr_err == 1'b0, "R10 hdr_err after reset", 64'(hdr_err), 64'd0);
    // stalls incl. code 0 (16), dual pair in slots 4/5 (R4 R5 R8)
    s = '{8'h01, 8'h02, 8'h03, 8'h00, 8'h04, 8'h05, 8'h0F};
    push_bundle(s, 64'h0);
    // barriers of each class (R6 R7)
    s = '{8'h11, 8'h21, 8'h81, 8'hB1, 8'h01, 8'h02, 8'h91};
    push_bundle(s, 64'h0);
    // malformed header, low and high pads (R2)
    s = '{8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01};
    push_bundle(s, 64'h8000_0000_0000_0001);
    // clean header follows, err must drop (R2), single-issue code 0x20
    s = '{8'h20, 8'h24, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01};
    push_bundle(s, 64'h0);
    // back-to-back pairs and a pair at bundle start (R8)
    s = '{8'h04, 8'h05, 8'h04, 8'h05, 8'h04, 8'h04, 8'h05};
    push_bundle(s, 64'h0);
    // a 0x04 in the last slot has no partner (R8)
    s = '{8'h01, 8'h01, 8'h01, 8'h01, 8'h01, 8'h05, 8'h04};
    push_bundle(s, 64'h0400_0000_0000_0002);
    run = 1;
    drain();
    // randomised handshakes and barrier completions
    rnd_ready = 1; rnd_done = 1; rnd_valid = 1;
    for (int b = 0; b < 30; b++) begin
      for (int k = 0; k < 7; k++) begin
        case ($urandom_range(0, 4))
          0: s[k] = 8'h04;
          1: s[k] = 8'h05;
          2: s[k] = 8'($urandom_range(0, 255)) & 8'hB3;
          default: s[k] = 8'($urandom_range(0, 15)) & 8'h03 | 8'($urandom_range(0, 1) << 4);
        endcase
      end
      push_bundle(s, ($urandom_range(0, 5) == 0) ? 64'h0000_0000_0000_0002 : 64'h0);
    end
    drain();
    summary();
  end
endmodule